// File: doc/BRIEF.md
# I2C Dual-Address Target Matcher

This block watches a shared I2C clock and data pair and decides, for a target-side controller, whether the transaction now being addressed belongs to it. It holds two target addresses, each with its own enable and its own choice of 7-bit or 10-bit form. It also recognises the general call address, and accepts it under one of two rules. The rule used depends on whether the transfer was started by the device's own master on the same wires (loopback) or by an external master.

The block drives an active-high open-drain pull request for SDA. It uses this to acknowledge accepted address bytes, and write-data bytes when the acknowledge enable for the current source is set. When an address phase ends in acceptance, it raises a strobe for one clock and reports three things: which slot matched, whether the transfer was a general call, and the direction. The bus inputs are synchronised to the system clock. START and STOP are decoded from SDA edges while SCL is high. No software steps through individual bytes.

Top module: `i2c_dual_addr_match`

## Requirements
- R1: While reset is held and on the first cycle after it, `sda_pull_o` and `match_stb_o` are 0. `hit_idx_o`, `hit_gc_o` and `hit_rd_o` read 0 after reset.
- R2: A slot that is enabled and in 7-bit mode accepts a first byte whose bits 7..1 equal its address bits 6..0. Bit 0 of that byte is the direction (1 = read). On acceptance the block pulls SDA low during the ninth clock and raises the strobe with `hit_rd_o` equal to bit 0.
- R3: A 7-bit match on slot 1 reports `hit_idx_o` = 1. When both slots match the same byte, slot 0 wins.
- R4: If no enabled slot matches, the block leaves SDA released during the ninth clock and raises no strobe. It then ignores every byte until the next START.
- R5: A 10-bit slot accepts a first byte 11110 a9 a8 0. It then accepts a second byte equal to address bits 7..0, which raises the strobe with `hit_rd_o` = 0. A header whose high bits match no enabled 10-bit slot is not acknowledged, and neither is a second byte that differs from the low bits.
- R6: After a 10-bit write match, a repeated START followed by 11110 a9 a8 1 with the same high bits is acknowledged. It raises the strobe with the same slot and `hit_rd_o` = 1. STOP forgets the 10-bit match, so such a header with no prior match is not acknowledged.
- R7: A 10-bit slot is never matched by a 7-bit byte. A first byte starting 11110 is always treated as a 10-bit header and never as a 7-bit address.
- R8: The first byte 0x00 is the general call. It is acknowledged when the own-master input is 1 and the loopback general-call enable is set, or when the own-master input is 0 and the external enable is set. On acceptance the strobe is raised with `hit_gc_o` = 1, `hit_rd_o` = 0 and `hit_idx_o` = 0. The byte 0x01 is never acknowledged.
- R9: Write-data bytes are acknowledged according to the enable of the accepted source: slot 0, slot 1, or general call. After a data byte that is not acknowledged, the block ignores the bus until the next START.
- R10: After a read address is accepted, the block never pulls SDA until the next START or STOP.
- R11: START and STOP are an SDA fall or rise while SCL is high. A repeated START restarts address decoding at any point. STOP releases SDA at once and makes the block idle. SDA changes while SCL is low are data.
- R12: `match_stb_o` is high for exactly one cycle per accepted address phase. The `hit_*` outputs change only with the strobe and hold otherwise.
- R13: The SDA pull request rises only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| own_master_i | input | 1 | 1 while the local master owns the current transfer |
| a0_en | input | 1 | Slot 0 enable |
| a0_ten | input | 1 | Slot 0 uses the 10-bit form |
| a0_addr | input | 10 | Slot 0 address (7-bit form uses bits 6..0) |
| a1_en | input | 1 | Slot 1 enable |
| a1_ten | input | 1 | Slot 1 uses the 10-bit form |
| a1_addr | input | 10 | Slot 1 address |
| gc_own_en | input | 1 | Accept general call from the own master |
| gc_ext_en | input | 1 | Accept general call from external masters |
| wack_a0 | input | 1 | Acknowledge write data sent to slot 0 |
| wack_a1 | input | 1 | Acknowledge write data sent to slot 1 |
| wack_gc | input | 1 | Acknowledge general-call write data |
| sda_pull_o | output | 1 | 1 = hold SDA low |
| match_stb_o | output | 1 | One-cycle pulse on an accepted address |
| hit_idx_o | output | 1 | Index of the matched slot |
| hit_gc_o | output | 1 | Accepted address was the general call |
| hit_rd_o | output | 1 | Accepted transfer is a read |

## Verification
Two pairs of functions can land on the same decision cycle. The first is the two slot comparators: both slots are given the same 7-bit address, so both hit on one byte, and the scoreboard has to see slot 0 reported. The second is the block's own acknowledge and the START/STOP detector, which share the SDA wire. The bench wires the pull request back onto the line it drives. Every loopback acknowledge therefore changes the sampled SDA, and a later byte still being decoded shows that no false condition was decoded. Each ninth-clock SDA level is judged against the value the requirements give, and each strobe is popped from an expectation queue.

// File: rtl/i2c_dam_pkg.sv
package i2c_dam_pkg;

    localparam int ADDR_W    = 10;
    localparam int NUM_SLOTS = 2;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = $clog2(BYTE_W);
    localparam int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int HI_W      = ADDR_W - BYTE_W;

    localparam logic [4:0]        TEN_PREFIX = 5'b11110;
    localparam logic [BYTE_W-1:0] GC_BYTE    = '0;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR1,
        PH_ADDR2,
        PH_WDATA,
        PH_READ
    } phase_e;

    typedef struct packed {
        logic              en;
        logic              ten;
        logic [ADDR_W-1:0] addr;
    } slot_cfg_t;

    typedef struct packed {
        logic             ack;
        logic             stb;
        logic             gc;
        logic             rd;
        logic             hi_load;
        logic             ten_set;
        logic             ten_clr;
        logic [IDX_W-1:0] idx;
        phase_e           nxt;
    } decision_t;

    function automatic logic is_ten_header(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:BYTE_W-5] == TEN_PREFIX;
    endfunction

    function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_SLOTS-1:0] v);
        logic [IDX_W-1:0] pick;
        pick = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (v[i]) pick = IDX_W'(i);
        end
        return pick;
    endfunction

endpackage

// File: rtl/i2c_dam_busmon.sv
module i2c_dam_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_d;
    logic                   sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // Conditions only while SCL stayed high across both samples
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_dam_slot.sv
module i2c_dam_slot
    import i2c_dam_pkg::*;
(
    input  slot_cfg_t         cfg_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [HI_W-1:0]   hi_i,
    output logic              hit7_o,
    output logic              hdr_ok_o,
    output logic              lo_ok_o
);

    logic seven_mode;
    logic ten_mode;

    assign seven_mode = cfg_i.en & ~cfg_i.ten;
    assign ten_mode   = cfg_i.en & cfg_i.ten;

    assign hit7_o   = seven_mode & (byte_i[BYTE_W-1:1] == cfg_i.addr[BYTE_W-2:0]);
    assign hdr_ok_o = ten_mode & (byte_i[HI_W:1] == cfg_i.addr[ADDR_W-1:BYTE_W]);
    assign lo_ok_o  = ten_mode & (hi_i == cfg_i.addr[ADDR_W-1:BYTE_W])
                               & (byte_i == cfg_i.addr[BYTE_W-1:0]);

endmodule

// File: rtl/i2c_dual_addr_match.sv
module i2c_dual_addr_match
    import i2c_dam_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              own_master_i,
    input  logic              a0_en,
    input  logic              a0_ten,
    input  logic [ADDR_W-1:0] a0_addr,
    input  logic              a1_en,
    input  logic              a1_ten,
    input  logic [ADDR_W-1:0] a1_addr,
    input  logic              gc_own_en,
    input  logic              gc_ext_en,
    input  logic              wack_a0,
    input  logic              wack_a1,
    input  logic              wack_gc,
    output logic              sda_pull_o,
    output logic              match_stb_o,
    output logic [IDX_W-1:0]  hit_idx_o,
    output logic              hit_gc_o,
    output logic              hit_rd_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    // Bus sampling
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_dam_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    // State
    phase_e            phase_q, nxt_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-2:0] shreg_q;
    logic              ack_pend_q, ack_val_q, in_ack_q;
    logic [HI_W-1:0]   hi_q, ten_hi_q;
    logic [NUM_SLOTS-1:0] cand_q;
    logic              ten_valid_q;
    logic [IDX_W-1:0]  ten_idx_q;
    logic [IDX_W-1:0]  src_idx_q;
    logic              src_gc_q;

    logic [BYTE_W-1:0] byte_n;
    assign byte_n = {shreg_q, sda_s};

    // Slot comparators
    slot_cfg_t            cfg [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] hit7_vec, hdr_vec, lo_vec, wack_vec;

    assign cfg[0]   = {a0_en, a0_ten, a0_addr};
    assign cfg[1]   = {a1_en, a1_ten, a1_addr};
    assign wack_vec = {wack_a1, wack_a0};

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        i2c_dam_slot u_slot (
            .cfg_i   (cfg[s]),
            .byte_i  (byte_n),
            .hi_i    (hi_q),
            .hit7_o  (hit7_vec[s]),
            .hdr_ok_o(hdr_vec[s]),
            .lo_ok_o (lo_vec[s])
        );
    end

    // Byte decision
    decision_t            dec;
    logic                 gc_ok;
    logic [NUM_SLOTS-1:0] lo_live;
    logic                 receiving;
    logic                 byte_done;

    assign gc_ok     = own_master_i ? gc_own_en : gc_ext_en;
    assign lo_live   = lo_vec & cand_q;
    assign receiving = (phase_q == PH_ADDR1) || (phase_q == PH_ADDR2) || (phase_q == PH_WDATA);
    assign byte_done = scl_rise && receiving && !in_ack_q && !ack_pend_q && (bit_cnt_q == LAST_BIT);

    always_comb begin
        dec     = '0;
        dec.nxt = PH_IDLE;
        unique case (phase_q)
            PH_ADDR1: begin
                if (is_ten_header(byte_n) && !byte_n[0]) begin
                    dec.ten_clr = 1'b1;
                    if (|hdr_vec) begin
                        dec.ack     = 1'b1;
                        dec.hi_load = 1'b1;
                        dec.nxt     = PH_ADDR2;
                    end
                end else if (is_ten_header(byte_n)) begin
                    if (ten_valid_q && (ten_hi_q == byte_n[HI_W:1])) begin
                        dec.ack = 1'b1;
                        dec.stb = 1'b1;
                        dec.rd  = 1'b1;
                        dec.idx = ten_idx_q;
                        dec.nxt = PH_READ;
                    end
                end else if (byte_n == GC_BYTE) begin
                    dec.ten_clr = 1'b1;
                    if (gc_ok) begin
                        dec.ack = 1'b1;
                        dec.stb = 1'b1;
                        dec.gc  = 1'b1;
                        dec.nxt = PH_WDATA;
                    end
                end else begin
                    dec.ten_clr = 1'b1;
                    if ((byte_n[BYTE_W-1:1] != '0) && (|hit7_vec)) begin
                        dec.ack = 1'b1;
                        dec.stb = 1'b1;
                        dec.rd  = byte_n[0];
                        dec.idx = lowest_set(hit7_vec);
                        dec.nxt = byte_n[0] ? PH_READ : PH_WDATA;
                    end
                end
            end
            PH_ADDR2: begin
                if (|lo_live) begin
                    dec.ack     = 1'b1;
                    dec.stb     = 1'b1;
                    dec.idx     = lowest_set(lo_live);
                    dec.ten_set = 1'b1;
                    dec.nxt     = PH_WDATA;
                end
            end
            PH_WDATA: begin
                dec.ack = src_gc_q ? wack_gc : wack_vec[src_idx_q];
                dec.nxt = dec.ack ? PH_WDATA : PH_IDLE;
            end
            default: ;
        endcase
    end

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            nxt_q       <= PH_IDLE;
            bit_cnt_q   <= '0;
            shreg_q     <= '0;
            ack_pend_q  <= 1'b0;
            ack_val_q   <= 1'b0;
            in_ack_q    <= 1'b0;
            hi_q        <= '0;
            ten_hi_q    <= '0;
            cand_q      <= '0;
            ten_valid_q <= 1'b0;
            ten_idx_q   <= '0;
            src_idx_q   <= '0;
            src_gc_q    <= 1'b0;
            sda_pull_o  <= 1'b0;
            match_stb_o <= 1'b0;
            hit_idx_o   <= '0;
            hit_gc_o    <= 1'b0;
            hit_rd_o    <= 1'b0;
        end else begin
            match_stb_o <= 1'b0;
            if (start_det) begin
                phase_q    <= PH_ADDR1;
                bit_cnt_q  <= '0;
                ack_pend_q <= 1'b0;
                in_ack_q   <= 1'b0;
                sda_pull_o <= 1'b0;
            end else if (stop_det) begin
                phase_q     <= PH_IDLE;
                bit_cnt_q   <= '0;
                ack_pend_q  <= 1'b0;
                in_ack_q    <= 1'b0;
                sda_pull_o  <= 1'b0;
                ten_valid_q <= 1'b0;
            end else if (scl_rise && receiving && !in_ack_q && !ack_pend_q) begin
                shreg_q   <= byte_n[BYTE_W-2:0];
                bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                if (byte_done) begin
                    bit_cnt_q   <= '0;
                    ack_pend_q  <= 1'b1;
                    ack_val_q   <= dec.ack;
                    nxt_q       <= dec.nxt;
                    match_stb_o <= dec.stb;
                    if (dec.stb) begin
                        hit_idx_o <= dec.idx;
                        hit_gc_o  <= dec.gc;
                        hit_rd_o  <= dec.rd;
                        src_idx_q <= dec.idx;
                        src_gc_q  <= dec.gc;
                    end
                    if (dec.hi_load) begin
                        hi_q   <= byte_n[HI_W:1];
                        cand_q <= hdr_vec;
                    end
                    if (dec.ten_clr) ten_valid_q <= 1'b0;
                    if (dec.ten_set) begin
                        ten_valid_q <= 1'b1;
                        ten_idx_q   <= dec.idx;
                        ten_hi_q    <= hi_q;
                    end
                end
            end else if (scl_fall && ack_pend_q) begin
                sda_pull_o <= ack_val_q;
                in_ack_q   <= 1'b1;
                ack_pend_q <= 1'b0;
            end else if (scl_fall && in_ack_q) begin
                sda_pull_o <= 1'b0;
                in_ack_q   <= 1'b0;
                phase_q    <= nxt_q;
            end
        end
    end

endmodule

// File: rtl/i2c_dam_chk.sv
module i2c_dam_chk (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic sda_pull,
    input logic match_stb,
    input logic hit_gc,
    input logic hit_rd
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sda_pull && !match_stb));

    a_r12_stb_single: assert property (@(posedge clk) disable iff (rst)
        match_stb |=> !match_stb);

    a_r13_pull_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_s);

    a_r11_cond_release: assert property (@(posedge clk) disable iff (rst)
        (start_det || stop_det) |=> !sda_pull);

    a_r8_gc_write: assert property (@(posedge clk) disable iff (rst)
        (match_stb && hit_gc) |-> !hit_rd);

endmodule

bind i2c_dual_addr_match i2c_dam_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_pull (sda_pull_o),
    .match_stb(match_stb_o),
    .hit_gc   (hit_gc_o),
    .hit_rd   (hit_rd_o)
);

// File: tb/i2c_dual_addr_match_bench.sv
module i2c_dual_addr_match_bench;

    localparam int HP = 10;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic own_master = 1'b0;
    logic a0_en, a0_ten, a1_en, a1_ten;
    logic [9:0] a0_addr, a1_addr;
    logic gc_own_en, gc_ext_en, wack_a0, wack_a1, wack_gc;
    logic sda_pull, match_stb, hit_idx, hit_gc, hit_rd;

    assign sda_line = sda_m & ~sda_pull;

    i2c_dual_addr_match u_i2c_dual_addr_match (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .own_master_i(own_master),
        .a0_en(a0_en), .a0_ten(a0_ten), .a0_addr(a0_addr),
        .a1_en(a1_en), .a1_ten(a1_ten), .a1_addr(a1_addr),
        .gc_own_en(gc_own_en), .gc_ext_en(gc_ext_en),
        .wack_a0(wack_a0), .wack_a1(wack_a1), .wack_gc(wack_gc),
        .sda_pull_o(sda_pull), .match_stb_o(match_stb),
        .hit_idx_o(hit_idx), .hit_gc_o(hit_gc), .hit_rd_o(hit_rd)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic  idx;
        logic  gc;
        logic  rd;
        string req;
    } exp_t;
    exp_t exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic finish_test();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && match_stb) begin
            if (exp_q.size() == 0) begin
                check(0, "R12", "unexpected strobe", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(hit_idx == e.idx, e.req, "hit_idx", int'(hit_idx), int'(e.idx));
                check(hit_gc == e.gc, e.req, "hit_gc", int'(hit_gc), int'(e.gc));
                check(hit_rd == e.rd, e.req, "hit_rd", int'(hit_rd), int'(e.rd));
            end
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WATCHDOG);
            finish_test();
        end
    end

    task automatic expect_hit(input logic idx, input logic gc, input logic rd, input string req);
        exp_t e;
        e.idx = idx; e.gc = gc; e.rd = rd; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b0; wclk(HP);
        scl_m = 1'b0; wclk(3);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wclk(HP);
        scl_m = 1'b1; wclk(HP);
        sda_m = 1'b0; wclk(HP);
        scl_m = 1'b0; wclk(3);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(HP);
        scl_m = 1'b1; wclk(HP);
        sda_m = 1'b1; wclk(HP);
        check(sda_pull == 1'b0, "R11", "pull after stop", int'(sda_pull), 0);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        bit got;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wclk(HP);
            scl_m = 1'b1; wclk(HP);
            scl_m = 1'b0; wclk(3);
        end
        sda_m = 1'b1; wclk(HP);
        scl_m = 1'b1; wclk(HP / 2);
        got = !sda_line;
        check(got == exp_ack, req, $sformatf("ack for byte %02h", b), int'(got), int'(exp_ack));
        wclk(HP - HP / 2);
        scl_m = 1'b0; wclk(3);
    endtask

    task automatic drain(input string req);
        wclk(4);
        check(exp_q.size() == 0, req, "pending expected strobes", exp_q.size(), 0);
    endtask

    task automatic set_defaults();
        a0_en = 1; a0_ten = 0; a0_addr = 10'h03A;
        a1_en = 1; a1_ten = 1; a1_addr = 10'h2C5;
        gc_own_en = 0; gc_ext_en = 1;
        wack_a0 = 1; wack_a1 = 0; wack_gc = 1;
        own_master = 0;
    endtask

    initial begin
        set_defaults();
        wclk(5);
        rst = 1'b0;
        wclk(1);
        // R1 reset state
        check(sda_pull == 0, "R1", "sda_pull", int'(sda_pull), 0);
        check(match_stb == 0, "R1", "match_stb", int'(match_stb), 0);
        check({hit_idx, hit_gc, hit_rd} == 3'b000, "R1", "hit fields",
              int'({hit_idx, hit_gc, hit_rd}), 0);
        wclk(5);

        // R2 7-bit write, R9 data ack on slot 0
        bus_start();
        expect_hit(0, 0, 0, "R2");
        send_byte(8'h74, 1, "R2");
        send_byte(8'h55, 1, "R9");
        bus_stop();

        // R2 7-bit read, R10 no pull afterwards
        bus_start();
        expect_hit(0, 0, 1, "R2");
        send_byte(8'h75, 1, "R2");
        send_byte(8'h00, 0, "R10");
        bus_stop();

        // R3 both slots same address: slot 0 wins; then slot 1 alone
        a1_ten = 0; a1_addr = 10'h03A;
        bus_start();
        expect_hit(0, 0, 0, "R3");
        send_byte(8'h74, 1, "R3");
        bus_stop();
        a0_en = 0;
        bus_start();
        expect_hit(1, 0, 0, "R3");
        send_byte(8'h74, 1, "R3");
        send_byte(8'h11, 0, "R9");
        bus_stop();
        set_defaults();

        // R4 mismatch then ignored until START
        bus_start();
        send_byte(8'h88, 0, "R4");
        send_byte(8'h74, 0, "R4");
        bus_stop();
        a0_en = 0;
        bus_start();
        send_byte(8'h74, 0, "R4");
        bus_stop();
        a0_en = 1;

        // R5 10-bit write
        bus_start();
        send_byte(8'hF4, 1, "R5");
        expect_hit(1, 0, 0, "R5");
        send_byte(8'hC5, 1, "R5");
        send_byte(8'h12, 0, "R9");
        bus_stop();
        bus_start();
        send_byte(8'hF4, 1, "R5");
        send_byte(8'hC6, 0, "R5");
        bus_stop();
        bus_start();
        send_byte(8'hF2, 0, "R5");
        bus_stop();

        // R6 10-bit read after repeated START
        bus_start();
        send_byte(8'hF4, 1, "R6");
        expect_hit(1, 0, 0, "R6");
        send_byte(8'hC5, 1, "R6");
        bus_rstart();
        expect_hit(1, 0, 1, "R6");
        send_byte(8'hF5, 1, "R6");
        bus_stop();
        bus_start();
        send_byte(8'hF5, 0, "R6");
        bus_stop();

        // R7 form separation
        bus_start();
        send_byte(8'h8A, 0, "R7");
        bus_stop();
        a0_addr = 10'h07A; a1_en = 0;
        bus_start();
        send_byte(8'hF4, 0, "R7");
        bus_stop();
        set_defaults();

        // R8 general call rules
        bus_start();
        expect_hit(0, 1, 0, "R8");
        send_byte(8'h00, 1, "R8");
        send_byte(8'h33, 1, "R9");
        bus_stop();
        own_master = 1;
        bus_start();
        send_byte(8'h00, 0, "R8");
        bus_stop();
        gc_own_en = 1;
        bus_start();
        expect_hit(0, 1, 0, "R8");
        send_byte(8'h00, 1, "R8");
        bus_stop();
        own_master = 0; gc_ext_en = 0;
        bus_start();
        send_byte(8'h00, 0, "R8");
        bus_stop();
        gc_ext_en = 1;
        bus_start();
        send_byte(8'h01, 0, "R8");
        bus_stop();

        // R11 repeated START mid-write, then bytes after STOP ignored
        bus_start();
        expect_hit(0, 0, 0, "R11");
        send_byte(8'h74, 1, "R11");
        send_byte(8'h0F, 1, "R11");
        bus_rstart();
        expect_hit(0, 0, 1, "R11");
        send_byte(8'h75, 1, "R11");
        bus_stop();
        scl_m = 1'b0; wclk(3);
        send_byte(8'h74, 0, "R11");
        bus_stop();

        // R9 data NACK then idle
        wack_a0 = 0;
        bus_start();
        expect_hit(0, 0, 0, "R9");
        send_byte(8'h74, 1, "R9");
        send_byte(8'h20, 0, "R9");
        wack_a0 = 1;
        send_byte(8'h21, 0, "R9");
        bus_stop();

        // R12 hit fields hold between strobes
        wclk(20);
        check(hit_rd == 0 && hit_gc == 0, "R12", "held hit fields",
              int'({hit_gc, hit_rd}), 0);
        drain("R12");
        finish_test();
    end

endmodule